// File: doc/BRIEF.md
# Cartridge Bank and Mirroring Translator

This block sits between a console's two buses and the cartridge memories. It watches CPU writes in the upper half of the CPU address space and captures them into a small set of bank registers. It then translates, without any clock delay, every video-bus address into a character-ROM address and every CPU address into a program-ROM address. It also drives the nametable RAM's address line 10 so that the two on-board nametables are arranged for horizontal or vertical scrolling, or collapse to one screen.

Register writes arrive on a plain strobe. The block accepts every write in the cycle it is offered and never pushes back, so there is no valid/ready pair and no back-pressure rule. The translation paths are purely combinational from the current register contents and the incoming address. The only delay is the register write itself, which takes effect at the clock edge that samples the strobe.

Top module: `cart_xlate`

## Requirements
- R1: A synchronous reset clears all four character banks, the program bank and the mirroring mode to 0. Afterwards a video address A gives character address {0, A[10:0]}, CPU addresses $8000-$BFFF land in program bank 0, and vram_a10 follows ppu_addr[10].
- R2: A write is decoded from CPU address bits 15:11 only, so bits 10:0 of the write address are ignored. With bit 15 set, bits 14:11 select the target: 0001 is character bank 0, 0011 bank 1, 0101 bank 2, 0111 bank 3, 1101 the mirroring mode and 1111 the program bank.
- R3: Video address bits 12:11 choose the character bank register: 0 for $0000-$07FF, 1 for $0800-$0FFF, 2 for $1000-$17FF and 3 for $1800-$1FFF.
- R4: The character-ROM address is the chosen 8-bit bank value in the upper bits, followed by video address bits 10:0.
- R5: For CPU addresses with bit 14 clear ($8000-$BFFF), the program-ROM address is the program bank in the upper bits, followed by CPU address bits 13:0. The program bank holds the low PRG_BANK_W (default 4) bits of the written byte.
- R6: For CPU addresses with bit 14 set ($C000-$FFFF), the upper bits of the program-ROM address are all ones, whatever the program bank holds.
- R7: The mirroring mode is bits 1:0 of the written byte. Mode 0 drives vram_a10 from ppu_addr[10], mode 1 from ppu_addr[11], mode 2 drives 0 and mode 3 drives 1.
- R8: A write with address bit 15 clear, or to any other slot with bit 15 set (for example $8000, $C800, $D800), leaves every register unchanged.
- R9: A write lands at the rising edge that samples cpu_wr high. Outputs show the old value during that cycle and the new value from the edge onward. Nothing changes while cpu_wr is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address, used for write decode and program translation |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 13 | Video-bus address, pattern space |
| chr_rom_addr | output | 19 | Translated character-ROM address |
| prg_rom_addr | output | 18 | Translated program-ROM address |
| vram_a10 | output | 1 | Nametable RAM address line 10 |

## Verification
Two functions can meet in one cycle: a character-bank write and a read through the same window. The write is held with cpu_wr high while ppu_addr points into the window that register serves. The output is sampled before the edge, where it must still show the old bank, and again after the edge, where it must show the new one. Random writes across the whole address space run alongside a bench model of the registers. Every few writes, random video and CPU addresses are translated and compared against that model.

// File: rtl/cart_xlate_pkg.sv
package cart_xlate_pkg;

  typedef enum logic [1:0] {
    MIR_VERT  = 2'd0,
    MIR_HORZ  = 2'd1,
    MIR_ONE_A = 2'd2,
    MIR_ONE_B = 2'd3
  } mirror_mode_e;

  typedef enum logic [2:0] {
    SLOT_NONE,
    SLOT_CHR0,
    SLOT_CHR1,
    SLOT_CHR2,
    SLOT_CHR3,
    SLOT_MIRROR,
    SLOT_PRG
  } wr_slot_e;

  // Only address bits 15:11 take part in the decode.
  function automatic wr_slot_e decode_slot(input logic [4:0] hi_bits);
    wr_slot_e s;
    s = SLOT_NONE;
    if (hi_bits[4]) begin
      case (hi_bits[3:0])
        4'b0001: s = SLOT_CHR0;
        4'b0011: s = SLOT_CHR1;
        4'b0101: s = SLOT_CHR2;
        4'b0111: s = SLOT_CHR3;
        4'b1101: s = SLOT_MIRROR;
        4'b1111: s = SLOT_PRG;
        default: s = SLOT_NONE;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/cart_regfile.sv
module cart_regfile
  import cart_xlate_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CHR_BANK_W = 8,
  parameter int PRG_BANK_W = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [4:0]                     wr_hi,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [3:0][CHR_BANK_W-1:0]     chr_bank,
  output logic [PRG_BANK_W-1:0]          prg_bank,
  output mirror_mode_e                   mir_mode
);

  localparam int NUM_WIN = 4;

  wr_slot_e slot;
  assign slot = decode_slot(wr_hi);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_chr
    always_ff @(posedge clk) begin
      if (rst) begin
        chr_bank[w] <= '0;
      end else if (wr_en && slot == wr_slot_e'(int'(SLOT_CHR0) + w)) begin
        chr_bank[w] <= wr_data[CHR_BANK_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_bank <= '0;
      mir_mode <= MIR_VERT;
    end else if (wr_en) begin
      if (slot == SLOT_PRG)    prg_bank <= wr_data[PRG_BANK_W-1:0];
      if (slot == SLOT_MIRROR) mir_mode <= mirror_mode_e'(wr_data[1:0]);
    end
  end

  // R1: everything clears on reset
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (chr_bank == '0 && prg_bank == '0 && mir_mode == MIR_VERT));

  // R8: writes outside the upper half change nothing
  p_low_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hi[4]) |=> ($stable(chr_bank) && $stable(prg_bank) && $stable(mir_mode)));

  // R9: no strobe, no change
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(chr_bank) && $stable(prg_bank) && $stable(mir_mode)));

  // R5: program bank write lands next cycle
  p_prg_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_hi == 5'b11111) |=> prg_bank == $past(wr_data[PRG_BANK_W-1:0]));

endmodule

// File: rtl/cart_chr_map.sv
module cart_chr_map #(
  parameter int CHR_BANK_W = 8,
  parameter int OFFSET_W   = 11
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [3:0][CHR_BANK_W-1:0]    chr_bank,
  input  logic [OFFSET_W+1:0]           ppu_addr,
  output logic [CHR_BANK_W+OFFSET_W-1:0] chr_addr
);

  logic [1:0] win;
  assign win      = ppu_addr[OFFSET_W+1:OFFSET_W];
  assign chr_addr = {chr_bank[win], ppu_addr[OFFSET_W-1:0]};

  // R4: low address bits pass through untouched
  p_offset_pass_r4: assert property (@(posedge clk) disable iff (rst)
    chr_addr[OFFSET_W-1:0] == ppu_addr[OFFSET_W-1:0]);

  // R3: window 0 always uses bank register 0
  p_window0_r3: assert property (@(posedge clk) disable iff (rst)
    (ppu_addr[OFFSET_W+1:OFFSET_W] == 2'd0) |-> chr_addr[CHR_BANK_W+OFFSET_W-1:OFFSET_W] == chr_bank[0]);

endmodule

// File: rtl/cart_prg_map.sv
module cart_prg_map #(
  parameter int PRG_BANK_W = 4,
  parameter int OFFSET_W   = 14
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [PRG_BANK_W-1:0]          prg_bank,
  input  logic [OFFSET_W:0]              cpu_addr,
  output logic [PRG_BANK_W+OFFSET_W-1:0] prg_addr
);

  localparam logic [PRG_BANK_W-1:0] LAST_BANK = '1;

  logic [PRG_BANK_W-1:0] bank_sel;
  assign bank_sel = cpu_addr[OFFSET_W] ? LAST_BANK : prg_bank;
  assign prg_addr = {bank_sel, cpu_addr[OFFSET_W-1:0]};

  // R6: upper window is pinned to the last bank
  p_fixed_bank_r6: assert property (@(posedge clk) disable iff (rst)
    cpu_addr[OFFSET_W] |-> &prg_addr[PRG_BANK_W+OFFSET_W-1:OFFSET_W]);

endmodule

// File: rtl/cart_mirror_sel.sv
module cart_mirror_sel
  import cart_xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  mirror_mode_e mode,
  input  logic         ppu_a10,
  input  logic         ppu_a11,
  output logic         vram_a10
);

  always_comb begin
    unique case (mode)
      MIR_VERT:  vram_a10 = ppu_a10;
      MIR_HORZ:  vram_a10 = ppu_a11;
      MIR_ONE_A: vram_a10 = 1'b0;
      default:   vram_a10 = 1'b1;
    endcase
  end

  // R7: single-screen modes ignore the video address
  p_single_screen_r7: assert property (@(posedge clk) disable iff (rst)
    mode[1] |-> vram_a10 == mode[0]);

  // R7: horizontal follows line 11
  p_horizontal_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == MIR_HORZ) |-> vram_a10 == ppu_a11);

endmodule

// File: rtl/cart_xlate.sv
module cart_xlate
  import cart_xlate_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CHR_BANK_W = 8,
  parameter int PRG_BANK_W = 4,
  parameter int CHR_OFS_W  = 11,
  parameter int PRG_OFS_W  = 14
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cpu_wr,
  input  logic [15:0]                      cpu_addr,
  input  logic [DATA_W-1:0]                cpu_wdata,
  input  logic [CHR_OFS_W+1:0]             ppu_addr,
  output logic [CHR_BANK_W+CHR_OFS_W-1:0]  chr_rom_addr,
  output logic [PRG_BANK_W+PRG_OFS_W-1:0]  prg_rom_addr,
  output logic                             vram_a10
);

  logic [3:0][CHR_BANK_W-1:0] chr_bank;
  logic [PRG_BANK_W-1:0]      prg_bank;
  mirror_mode_e               mir_mode;

  cart_regfile #(
    .DATA_W(DATA_W), .CHR_BANK_W(CHR_BANK_W), .PRG_BANK_W(PRG_BANK_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(cpu_wr), .wr_hi(cpu_addr[15:11]),
    .wr_data(cpu_wdata), .chr_bank(chr_bank), .prg_bank(prg_bank),
    .mir_mode(mir_mode)
  );

  cart_chr_map #(.CHR_BANK_W(CHR_BANK_W), .OFFSET_W(CHR_OFS_W)) u_chr (
    .clk(clk), .rst(rst), .chr_bank(chr_bank), .ppu_addr(ppu_addr),
    .chr_addr(chr_rom_addr)
  );

  cart_prg_map #(.PRG_BANK_W(PRG_BANK_W), .OFFSET_W(PRG_OFS_W)) u_prg (
    .clk(clk), .rst(rst), .prg_bank(prg_bank), .cpu_addr(cpu_addr[PRG_OFS_W:0]),
    .prg_addr(prg_rom_addr)
  );

  cart_mirror_sel u_mir (
    .clk(clk), .rst(rst), .mode(mir_mode),
    .ppu_a10(ppu_addr[10]), .ppu_a11(ppu_addr[11]), .vram_a10(vram_a10)
  );

endmodule

// File: tb/cart_xlate_tb.sv
module cart_xlate_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [12:0] ppu_addr = 13'h0000;
  logic [18:0] chr_rom_addr;
  logic [17:0] prg_rom_addr;
  logic        vram_a10;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_chr [4];
  logic [3:0] m_prg;
  logic [1:0] m_mir;

  always #4 clk = ~clk;

  cart_xlate u_dut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .chr_rom_addr(chr_rom_addr),
    .prg_rom_addr(prg_rom_addr), .vram_a10(vram_a10)
  );

  function automatic logic [18:0] exp_chr(input logic [12:0] a);
    return {m_chr[a[12:11]], a[10:0]};
  endfunction

  function automatic logic [17:0] exp_prg(input logic [15:0] a);
    return a[14] ? {4'hF, a[13:0]} : {m_prg, a[13:0]};
  endfunction

  function automatic logic exp_a10(input logic [12:0] a);
    case (m_mir)
      2'd0:    return a[10];
      2'd1:    return a[11];
      2'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    if (a[15]) begin
      case (a[14:11])
        4'b0001: m_chr[0] = d;
        4'b0011: m_chr[1] = d;
        4'b0101: m_chr[2] = d;
        4'b0111: m_chr[3] = d;
        4'b1101: m_mir    = d[1:0];
        4'b1111: m_prg    = d[3:0];
        default: ;
      endcase
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic probe(input string req, input logic [12:0] pa, input logic [15:0] ca);
    ppu_addr = pa; cpu_addr = ca;
    #1;
    check({req, " chr"}, 32'(chr_rom_addr), 32'(exp_chr(pa)));
    check({req, " prg"}, 32'(prg_rom_addr), 32'(exp_prg(ca)));
    check({req, " a10"}, 32'(vram_a10),     32'(exp_a10(pa)));
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) m_chr[i] = 8'h00;
    m_prg = 4'h0; m_mir = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    probe("R1", 13'h0ABC, 16'h9234);
    probe("R1", 13'h1C55, 16'hA001);

    // R2: low write address bits ignored; R3/R4 per window
    bus_write(16'h8FFF, 8'h11);
    bus_write(16'h9801, 8'h22);
    bus_write(16'hA9AB, 8'h33);
    bus_write(16'hBC00, 8'h44);
    probe("R2", 13'h0123, 16'h8000);
    probe("R3", 13'h0923, 16'h8000);
    probe("R3", 13'h1123, 16'h8000);
    probe("R4", 13'h1FFF, 16'h8000);

    // R5 / R6: program windows
    bus_write(16'hF800, 8'hA7);
    probe("R5", 13'h0000, 16'hBFFF);
    probe("R6", 13'h0000, 16'hC000);
    probe("R6", 13'h0000, 16'hFFFF);

    // R7: all four mirroring modes
    for (int m = 0; m < 4; m++) begin
      bus_write(16'hE8F0, 8'hFC | 8'(m));
      probe("R7", 13'h0400, 16'h8000);
      probe("R7", 13'h0800, 16'h8000);
      probe("R7", 13'h0C00, 16'h8000);
    end

    // R8: ignored targets
    bus_write(16'h0800, 8'hEE);
    bus_write(16'h7FFF, 8'hEE);
    bus_write(16'h8000, 8'hEE);
    bus_write(16'hC800, 8'hEE);
    bus_write(16'hD800, 8'hEE);
    bus_write(16'h9000, 8'hEE);
    probe("R8", 13'h0100, 16'h8100);
    probe("R8", 13'h1900, 16'h8100);

    // R9: write and read through the same window in one cycle
    @(negedge clk);
    ppu_addr = 13'h0042; cpu_addr = 16'h8800; cpu_wdata = 8'h5A; cpu_wr = 1'b1;
    #1;
    check("R9 before edge", 32'(chr_rom_addr), 32'(exp_chr(13'h0042)));
    @(posedge clk); #1;
    m_chr[0] = 8'h5A;
    check("R9 after edge", 32'(chr_rom_addr), 32'(exp_chr(13'h0042)));
    @(negedge clk);
    cpu_wr = 1'b0; cpu_wdata = 8'h99;
    @(negedge clk);
    check("R9 idle", 32'(chr_rom_addr), 32'(exp_chr(13'h0042)));

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ($urandom % 2 == 0) a[15] = 1'b1;
      bus_write(a, 8'($urandom));
      if (i % 4 == 0) probe("R3 random", 13'($urandom), 16'($urandom) | 16'h8000);
    end

    // R1: reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) m_chr[i] = 8'h00;
    m_prg = 4'h0; m_mir = 2'd0;
    probe("R1 rereset", 13'h1A5A, 16'h8765);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule